// File: doc/BRIEF.md
# Buck Converter Gate Sequencer

This block generates the two gate enables of a synchronous step-down converter: `gh` for the high-side switch and `gl` for the synchronous rectifier. A free-running period counter serves as a digital ramp. Each period the high side is requested from the period start until the ramp reaches a duty word, so the pulse is trailing-edge modulated. The duty word is captured once per period. The two enables are registered and never overlap, and a fixed number of idle clocks separates one switch turning off from the other turning on.

Start-up is asynchronous. The rectifier stays off until the high side has actually been driven, or until the soft-start comparator input says the soft-start level is high. This gate is re-armed by reset and by the fault hold.

During long stretches at 100% duty, a timeout cuts the high-side request at mid-period and lets the low side conduct for the rest of that period, which recharges the bootstrap capacitor. A fault-hold input forces both enables low.

Top module: `buck_gate_seq`

## Requirements
- R1: While `rst_n` is low, `gh` and `gl` are both 0. The ramp restarts at phase 0 and the captured duty is 0. The first clock edge with `rst_n` high moves the ramp to phase 1.
- R2: A period lasts `PERIOD` clocks, phases 0 to `PERIOD-1`. For a steady duty D with `DEAD_CYC < D <= PERIOD-DEAD_CYC-2`, `gh` is high for the D-`DEAD_CYC` clocks of phases `DEAD_CYC+1` through D, and `gl` is high for `PERIOD`-D-`DEAD_CYC` clocks per period.
- R3: A steady duty of 0 keeps `gh` low and `gl` high for the whole period, once the rectifier is enabled. A steady duty of `PERIOD` or more (values above `PERIOD` are clamped) keeps `gh` high for the whole period and `gl` low.
- R4: The duty word is captured only at the last phase of a period. A change in the middle of a period leaves that period's pulse unchanged and takes effect in the next period.
- R5: `gh` and `gl` are never high in the same clock. Between one enable falling and the other rising there are at least `DEAD_CYC` clocks with both low, and exactly `DEAD_CYC` on a direct hand-over.
- R6: After reset, `gl` cannot rise until `gh` has been high at least once, unless `ss_high` is 1. With duty 0 and `ss_high` low, both enables stay low. With `ss_high` high, `gl` turns on.
- R7: `hold_off` high forces both enables low from the next clock on. It also clears the record that the high side was driven, so after release the start-up gating of R6 applies again.
- R8: A period is full when the high-side request stays on in every phase. After `FULL_LIMIT` consecutive full periods, the next period drops the request from phase `PERIOD/2` on. In that period `gh` is high for `PERIOD/2+1` clocks and `gl` for `PERIOD/2-DEAD_CYC-1` clocks.
- R9: Any period that is not full clears the consecutive-full count, so the timeout needs `FULL_LIMIT` new full periods in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| duty | input | $clog2(PERIOD+1) | Duty command in ramp steps; 0 is off, `PERIOD` or more is fully on |
| ss_high | input | 1 | Soft-start level above its threshold; enables the rectifier before the first high-side pulse |
| hold_off | input | 1 | Fault hold; forces both switches off |
| gh | output | 1 | High-side gate enable |
| gl | output | 1 | Low-side gate enable |

## Verification
The hardest behaviour to reach from the ports is the full-duty timeout. It only fires after twenty uninterrupted full periods, and a single partial period must restart the count. The stimulus holds the duty at 100% for fifteen periods, inserts one partial period, and then holds 100% again. The bench requires no low-side pulse until the twentieth fresh full period has ended, and then checks the exact high and low counts of the mid-period cut. The start-up gate is reached twice: once directly after reset, and once after a fault hold with zero duty. Both times the bench confirms that the rectifier stays dark until the soft-start flag rises or a high-side pulse occurs.

// File: rtl/buck_gate_seq.sv
module buck_gate_seq #(
  parameter int PERIOD     = 16,
  parameter int DEAD_CYC   = 2,
  parameter int FULL_LIMIT = 20,
  localparam int CW = $clog2(PERIOD + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] duty,
  input  logic          ss_high,
  input  logic          hold_off,
  output logic          gh,
  output logic          gl
);
  localparam int PW = $clog2(PERIOD);
  localparam int FW = $clog2(FULL_LIMIT + 1);
  localparam int DW = $clog2(DEAD_CYC + 1);

  logic [PW-1:0] ph;
  logic [CW-1:0] duty_q;
  logic [FW-1:0] full_cnt;
  logic [DW-1:0] idle;
  logic          dropped, armed, gh_q, gl_q;

  wire           last      = ph == PW'(PERIOD - 1);
  wire [CW-1:0]  duty_c    = (duty > CW'(PERIOD)) ? CW'(PERIOD) : duty;
  wire           force_off = (full_cnt == FW'(FULL_LIMIT)) && (ph >= PW'(PERIOD / 2));
  wire           hi_req    = (CW'(ph) < duty_q) && !force_off && !hold_off;
  wire           lo_req    = !hi_req && (armed || ss_high) && !hold_off;
  wire           idle_done = idle >= DW'(DEAD_CYC - 1);
  wire           gh_d      = hi_req && !gl_q && (gh_q || idle_done);
  wire           gl_d      = lo_req && !gh_q && (gl_q || idle_done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= '0;
      duty_q   <= '0;
      full_cnt <= '0;
      dropped  <= 1'b0;
      armed    <= 1'b0;
      idle     <= DW'(DEAD_CYC - 1);
      gh_q     <= 1'b0;
      gl_q     <= 1'b0;
    end else begin
      ph <= last ? '0 : ph + PW'(1);
      if (last) begin
        duty_q  <= duty_c;
        dropped <= 1'b0;
        if (dropped || !hi_req)                 full_cnt <= '0;
        else if (full_cnt != FW'(FULL_LIMIT))   full_cnt <= full_cnt + FW'(1);
      end else begin
        dropped <= dropped | !hi_req;
      end
      armed <= hold_off ? 1'b0 : (armed | gh_q);
      if (gh_q || gl_q)  idle <= '0;
      else if (!idle_done) idle <= idle + DW'(1);
      gh_q <= gh_d;
      gl_q <= gl_d;
    end
  end

  assign gh = gh_q;
  assign gl = gl_q;
endmodule

module buck_gate_seq_chk #(
  parameter int DEAD_CYC = 2
) (
  input logic clk,
  input logic rst_n,
  input logic ss_high,
  input logic hold_off,
  input logic gh,
  input logic gl
);
  logic       seen;
  logic [7:0] idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen <= 1'b0;
      idle <= 8'hFF;
    end else begin
      seen <= hold_off ? 1'b0 : (seen | gh);
      if (gh || gl)         idle <= '0;
      else if (idle != 8'hFF) idle <= idle + 8'd1;
    end
  end

  assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(gh && gl));

  assert_dead_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gh) || $rose(gl)) |-> (int'(idle) >= DEAD_CYC));

  assert_hold_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hold_off |=> (!gh && !gl));

  assert_startup_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gl) |-> (seen || $past(ss_high)));
endmodule

bind buck_gate_seq buck_gate_seq_chk #(.DEAD_CYC(DEAD_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .ss_high(ss_high), .hold_off(hold_off), .gh(gh), .gl(gl)
);

// File: tb/sim_buck_gate_seq.sv
module sim_buck_gate_seq;
  localparam int P  = 16;
  localparam int DC = 2;
  localparam int FL = 20;
  localparam int DW = $clog2(P + 1);
  localparam int NR = 8;

  localparam int ROW_DUTY [NR] = '{3, 8, 12, 0, P, 20, 8, 8};
  localparam int ROW_HOLD [NR] = '{0, 0, 0, 0, 0, 0, 1, 0};
  localparam int ROW_EGH  [NR] = '{3-DC, 8-DC, 12-DC, 0, P, P, 0, 8-DC};
  localparam int ROW_EGL  [NR] = '{P-3-DC, P-8-DC, P-12-DC, P, 0, 0, 0, P-8-DC};

  logic clk = 0, rst_n = 0, ss_high = 0, hold_off = 0;
  logic [DW-1:0] duty = '0;
  logic gh, gl;

  always #5 clk = ~clk;

  buck_gate_seq #(.PERIOD(P), .DEAD_CYC(DC), .FULL_LIMIT(FL)) u0 (
    .clk(clk), .rst_n(rst_n), .duty(duty), .ss_high(ss_high),
    .hold_off(hold_off), .gh(gh), .gl(gl)
  );

  int n_chk = 0, n_fail = 0, bad_overlap = 0, bad_gap = 0, idle = 100;
  bit pgh = 0, pgl = 0, finished = 0;

  always @(negedge clk) if (rst_n) begin
    if (gh && gl) bad_overlap++;
    if (((gh && !pgh) || (gl && !pgl)) && idle < DC) bad_gap++;
    if (gh || gl) idle = 0; else idle++;
    pgh = gh;
    pgl = gl;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic measure(output int ngh, output int ngl);
    ngh = 0;
    ngl = 0;
    for (int i = 0; i < P; i++) begin
      if (gh) ngh++;
      if (gl) ngl++;
      @(negedge clk);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R2 actual=timeout expected=completion");
    wrap_up();
  end

  initial begin
    int a, b, gl_sum;
    repeat (3) @(negedge clk);
    chk("R1 gh in reset", int'(gh), 0);
    chk("R1 gl in reset", int'(gl), 0);
    rst_n = 1;

    for (int k = 0; k < 2; k++) begin
      measure(a, b);
      chk("R6 gh startup", a, 0);
      chk("R6 gl gated at startup", b, 0);
    end
    ss_high = 1;
    measure(a, b);
    measure(a, b);
    chk("R6 gl enabled by ss_high", b, P);
    ss_high = 0;
    measure(a, b);

    for (int r = 0; r < NR; r++) begin
      duty = DW'(ROW_DUTY[r]);
      hold_off = ROW_HOLD[r][0];
      measure(a, b);
      measure(a, b);
      measure(a, b);
      if (ROW_HOLD[r] != 0) begin
        chk("R7 gh under hold", a, ROW_EGH[r]);
        chk("R7 gl under hold", b, ROW_EGL[r]);
      end else if (ROW_DUTY[r] == 0 || ROW_DUTY[r] >= P) begin
        chk("R3 gh extreme duty", a, ROW_EGH[r]);
        chk("R3 gl extreme duty", b, ROW_EGL[r]);
      end else begin
        chk("R2 gh steady duty", a, ROW_EGH[r]);
        chk("R2 gl steady duty", b, ROW_EGL[r]);
      end
    end

    a = 0;
    for (int i = 0; i < P; i++) begin
      if (i == 4) duty = DW'(12);
      if (gh) a++;
      @(negedge clk);
    end
    chk("R4 mid-period change ignored", a, 8 - DC);
    measure(a, b);
    chk("R4 gh new duty next period", a, 12 - DC);
    chk("R4 gl new duty next period", b, P - 12 - DC);

    hold_off = 1;
    duty = '0;
    measure(a, b);
    chk("R7 gh off after hold", a, 0);
    chk("R7 gl off one clock after hold", b, 1);
    measure(a, b);
    chk("R7 both off in hold", a + b, 0);
    hold_off = 0;
    measure(a, b);
    measure(a, b);
    chk("R7 gl re-gated after hold", b, 0);

    gl_sum = 0;
    duty = DW'(P);
    for (int k = 0; k < 38; k++) begin
      if (k == 15) duty = DW'(8);
      if (k == 16) duty = DW'(P);
      measure(a, b);
      if ((k >= 2 && k <= 15) || (k >= 18 && k <= 36)) gl_sum += b;
      if (k == 37) begin
        chk("R8 gh in timeout period", a, P/2 + 1);
        chk("R8 gl in timeout period", b, P/2 - DC - 1);
      end
    end
    chk("R9 no refresh before fresh full run", gl_sum, 0);

    chk("R5 overlap cycles", bad_overlap, 0);
    chk("R5 short dead gaps", bad_gap, 0);
    wrap_up();
  end
endmodule